// File: doc/BRIEF.md
# Sensor Scratchpad Command Engine

This block is the slave-side handler for the function commands that act on a nine-byte sensor scratchpad reached over a bit-serial, one-wire style bus. A slot layer in front of it delivers already-decoded command bytes, single data bits from write slots, and a strobe for every read slot. The engine returns the bit that the slave puts on the line for each read slot. Reset and presence signalling, ROM-level addressing and the temperature measurement itself stay outside the block. The two temperature bytes arrive on a parallel input.

Four commands are handled. A write fills the high-alarm, low-alarm and configuration bytes. A read streams all nine bytes out, and the last of them is a CRC over the other eight. A copy saves the three writable bytes into a non-volatile shadow. A recall reloads them from that shadow. The shadow is modelled as registers, and each access to it takes a programmable number of clock cycles. Reset stands for power-up and loads the shadow contents into the scratchpad. The configuration byte holds the two resolution bits, and the block turns them into a conversion-duration output that is scaled from a full-time parameter.

Top module: `scratch_cmd_engine`

## Requirements
- R1: After command 0x4E, the next 24 write bits land in the high-alarm byte (scratchpad index 2), then the low-alarm byte (index 3), then the configuration byte (index 4). Each byte arrives least significant bit first. Bits after the 24th are ignored.
- R2: After command 0xBE, successive read slots return 72 bits: bytes 0 through 8 in order, each least significant bit first. Byte 0 is `tempLo`, byte 1 is `tempHi`, bytes 2..4 are the writable bytes, and bytes 5, 6 and 7 are the fixed values 0xFF, 0x0C and 0x10.
- R3: Byte 8 is a CRC-8 with polynomial x^8+x^5+x^4+1 and a zero start value. Bytes 0..7 are fed into it least significant bit first, which is the reflected form with constant 0x8C.
- R4: The configuration byte always reads as bit 7 = 0, bit 6 = R1, bit 5 = R0 and bits 4..0 = 1. A write to it changes only bits 6 and 5.
- R5: Command 0x48 stores bytes 2..4 into the non-volatile shadow after NV_CYCLES clock cycles and leaves the scratchpad unchanged. While the copy runs, read slots return 0.
- R6: Command 0xB8 reloads bytes 2..4 from the shadow. The read-slot bit is 0 for exactly NV_CYCLES cycles after the command is taken and 1 afterwards.
- R7: After reset, bytes 2..4 hold the shadow's initial contents, and the resolution bits default to 11.
- R8: `convCycles` equals CONV_FULL shifted right by 3, 2, 1 or 0 for resolution bits 00, 01, 10 or 11.
- R9: A bus reset in the middle of a write ends the write. Bytes already complete stay written, the partial byte is dropped, and later write bits are ignored.
- R10: A bus reset in the middle of a read ends the read, and the read-slot bit goes back to 1. The next read command starts again at bit 0 of byte 0.
- R11: An unknown command code is ignored. Read slots then return 1, and write bits change nothing.
- R12: When no read is in progress and no shadow access runs, the read-slot bit is 1. Commands that arrive while a shadow access is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-up) |
| busReset | input | 1 | Bus reset seen by the slot layer; aborts a transfer |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Decoded function command |
| wrBitValid | input | 1 | Write-slot bit strobe |
| wrBit | input | 1 | Write-slot data bit |
| rdSlotReq | input | 1 | Read slot consumed; advance to the next bit |
| rdBit | output | 1 | Bit to drive in the current read slot |
| tempLo | input | 8 | Temperature low byte (scratchpad byte 0) |
| tempHi | input | 8 | Temperature high byte (scratchpad byte 1) |
| convCycles | output | CONV_W | Conversion duration selected by the resolution bits |

## Verification
Assertions check on every cycle that the write and read pointers stay within their bounds. They also check that a bus reset during a write or read returns the engine to idle, that a copy or recall moves exactly the current register values across, that the shadow counter stays below NV_CYCLES, and that the line answers 1 when the engine is idle. Only the bench scenarios can show the rest. That includes the order and bit order of the serial bytes, the CRC value, the masking of the reserved configuration bits, the exact length of the busy window, and that partial bytes, unknown codes and commands arriving while the shadow is busy leave the scratchpad untouched.

// File: rtl/scratch_cmd_pkg.sv
package scratch_cmd_pkg;

  localparam logic [7:0] CMD_WRITE  = 8'h4E;
  localparam logic [7:0] CMD_READ   = 8'hBE;
  localparam logic [7:0] CMD_COPY   = 8'h48;
  localparam logic [7:0] CMD_RECALL = 8'hB8;

  localparam int SP_BYTES = 9;
  localparam int SP_BITS  = SP_BYTES * 8;
  localparam int IDX_W    = $clog2(SP_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_COPY,
    ST_RECALL
  } engState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic             shiftEn;
    logic             commitEn;
    logic [1:0]       commitIdx;
    logic             rdActive;
    logic [IDX_W-1:0] rdIdx;
    logic             nvBusy;
    logic             copyDo;
    logic             recallDo;
  } ctlStrobe_t;

endpackage

// File: rtl/scratch_cmd_ctrl.sv
module scratch_cmd_ctrl
  import scratch_cmd_pkg::*;
#(
  parameter int NV_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReset,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       wrBitValid,
  input  logic       rdSlotReq,
  output ctlStrobe_t ctl
);

  localparam int NV_W = $clog2(NV_CYCLES + 1);
  localparam logic [NV_W-1:0]  NV_LAST = NV_W'(NV_CYCLES - 1);
  localparam logic [IDX_W-1:0] RD_LAST = IDX_W'(SP_BITS - 1);

  engState_t        state;
  logic [2:0]       bitCnt;
  logic [1:0]       byteCnt;
  logic [IDX_W-1:0] rdIdx;
  logic [NV_W-1:0]  nvCnt;
  logic             nvLast;

  assign nvLast = (nvCnt == NV_LAST);

  always_comb begin
    ctl           = '0;
    ctl.shiftEn   = (state == ST_WRITE) && wrBitValid && !busReset;
    ctl.commitEn  = ctl.shiftEn && (bitCnt == 3'd7);
    ctl.commitIdx = byteCnt;
    ctl.rdActive  = (state == ST_READ);
    ctl.rdIdx     = rdIdx;
    ctl.nvBusy    = (state == ST_COPY) || (state == ST_RECALL);
    ctl.copyDo    = (state == ST_COPY) && nvLast;
    ctl.recallDo  = (state == ST_RECALL) && nvLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      rdIdx   <= '0;
      nvCnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmdValid && !busReset) begin
            unique case (cmdByte)
              CMD_WRITE: begin
                state   <= ST_WRITE;
                bitCnt  <= '0;
                byteCnt <= '0;
              end
              CMD_READ: begin
                state <= ST_READ;
                rdIdx <= '0;
              end
              CMD_COPY: begin
                state <= ST_COPY;
                nvCnt <= '0;
              end
              CMD_RECALL: begin
                state <= ST_RECALL;
                nvCnt <= '0;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_WRITE: begin
          if (busReset) begin
            state <= ST_IDLE;
          end else if (wrBitValid) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              if (byteCnt == 2'd2) state <= ST_IDLE;
              else byteCnt <= byteCnt + 2'd1;
            end
          end
        end
        ST_READ: begin
          if (busReset) begin
            state <= ST_IDLE;
          end else if (rdSlotReq) begin
            if (rdIdx == RD_LAST) state <= ST_IDLE;
            else rdIdx <= rdIdx + 1'b1;
          end
        end
        ST_COPY, ST_RECALL: begin
          if (nvLast) state <= ST_IDLE;
          else nvCnt <= nvCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_wr_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE) |-> (byteCnt < 2'd3));

  p_rd_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ) |-> (rdIdx <= RD_LAST));

  p_nv_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_COPY) || (state == ST_RECALL)) |-> (nvCnt <= NV_LAST));

  p_wr_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WRITE) && busReset) |=> (state == ST_IDLE));

  p_rd_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_READ) && busReset) |=> (state == ST_IDLE));

  p_busy_ignores_cmd_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_COPY) && !nvLast) |=> (state == ST_COPY));

endmodule

// File: rtl/scratch_cmd_datapath.sv
module scratch_cmd_datapath
  import scratch_cmd_pkg::*;
#(
  parameter logic [7:0] NV_TH_INIT  = 8'h4B,
  parameter logic [7:0] NV_TL_INIT  = 8'h46,
  parameter logic [1:0] NV_RES_INIT = 2'b11,
  parameter logic [7:0] FIX5        = 8'hFF,
  parameter logic [7:0] FIX6        = 8'h0C,
  parameter logic [7:0] FIX7        = 8'h10
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  input  logic       wrBit,
  input  logic [7:0] tempLo,
  input  logic [7:0] tempHi,
  output logic       rdBit,
  output logic [1:0] resBits
);

  localparam int IMG_BITS = (SP_BYTES - 1) * 8;

  logic [7:0] shiftReg;
  logic [7:0] newByte;
  logic [7:0] thReg, tlReg;
  logic [1:0] resReg;
  logic [7:0] nvTh, nvTl;
  logic [1:0] nvRes;
  logic [7:0] cfgByte;
  logic [IMG_BITS-1:0] image;
  logic [7:0] crcByte;
  logic [SP_BITS-1:0] frame;

  function automatic logic [7:0] crc8Refl(input logic [IMG_BITS-1:0] data);
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = 0; i < IMG_BITS; i++) begin
      fb = c[0] ^ data[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  assign newByte = {wrBit, shiftReg[7:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      thReg    <= NV_TH_INIT;
      tlReg    <= NV_TL_INIT;
      resReg   <= NV_RES_INIT;
      nvTh     <= NV_TH_INIT;
      nvTl     <= NV_TL_INIT;
      nvRes    <= NV_RES_INIT;
    end else begin
      if (ctl.shiftEn) shiftReg <= newByte;
      if (ctl.commitEn) begin
        unique case (ctl.commitIdx)
          2'd0:    thReg  <= newByte;
          2'd1:    tlReg  <= newByte;
          default: resReg <= newByte[6:5];
        endcase
      end
      if (ctl.copyDo) begin
        nvTh  <= thReg;
        nvTl  <= tlReg;
        nvRes <= resReg;
      end
      if (ctl.recallDo) begin
        thReg  <= nvTh;
        tlReg  <= nvTl;
        resReg <= nvRes;
      end
    end
  end

  assign cfgByte = {1'b0, resReg, 5'b11111};
  assign image   = {FIX7, FIX6, FIX5, cfgByte, tlReg, thReg, tempHi, tempLo};
  assign crcByte = crc8Refl(image);
  assign frame   = {crcByte, image};
  assign resBits = resReg;

  always_comb begin
    if (ctl.rdActive)    rdBit = frame[ctl.rdIdx];
    else if (ctl.nvBusy) rdBit = 1'b0;
    else                 rdBit = 1'b1;
  end

  p_copy_moves_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.copyDo |=> (nvTh == $past(thReg) && nvTl == $past(tlReg) && nvRes == $past(resReg)));

  p_recall_moves_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.recallDo |=> (thReg == $past(nvTh) && tlReg == $past(nvTl) && resReg == $past(nvRes)));

  p_busy_answers_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.nvBusy && !ctl.rdActive) |-> !rdBit);

endmodule

// File: rtl/scratch_cmd_engine.sv
module scratch_cmd_engine
  import scratch_cmd_pkg::*;
#(
  parameter int          NV_CYCLES   = 20,
  parameter int          CONV_W      = 32,
  parameter int          CONV_FULL   = 96000000,
  parameter logic [7:0]  NV_TH_INIT  = 8'h4B,
  parameter logic [7:0]  NV_TL_INIT  = 8'h46,
  parameter logic [1:0]  NV_RES_INIT = 2'b11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              wrBitValid,
  input  logic              wrBit,
  input  logic              rdSlotReq,
  output logic              rdBit,
  input  logic [7:0]        tempLo,
  input  logic [7:0]        tempHi,
  output logic [CONV_W-1:0] convCycles
);

  localparam logic [CONV_W-1:0] FULL_TIME = CONV_W'(CONV_FULL);

  ctlStrobe_t ctlBus;
  logic [1:0] resBits;

  scratch_cmd_ctrl #(
    .NV_CYCLES(NV_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busReset  (busReset),
    .cmdValid  (cmdValid),
    .cmdByte   (cmdByte),
    .wrBitValid(wrBitValid),
    .rdSlotReq (rdSlotReq),
    .ctl       (ctlBus)
  );

  scratch_cmd_datapath #(
    .NV_TH_INIT (NV_TH_INIT),
    .NV_TL_INIT (NV_TL_INIT),
    .NV_RES_INIT(NV_RES_INIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctlBus),
    .wrBit  (wrBit),
    .tempLo (tempLo),
    .tempHi (tempHi),
    .rdBit  (rdBit),
    .resBits(resBits)
  );

  assign convCycles = FULL_TIME >> (2'd3 - resBits);

  p_conv_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    convCycles <= FULL_TIME);

  p_idle_high_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlBus.rdActive && !ctlBus.nvBusy) |-> rdBit);

endmodule

// File: tb/scratch_cmd_engine_tb.sv
module scratch_cmd_engine_tb;

  localparam int NV  = 6;
  localparam int CW  = 32;
  localparam int CF  = 800;
  localparam logic [7:0] TH0 = 8'h4B;
  localparam logic [7:0] TL0 = 8'h46;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdByte = '0;
  logic wrBitValid = 1'b0;
  logic wrBit = 1'b0;
  logic rdSlotReq = 1'b0;
  logic rdBit;
  logic [7:0] tempLo = 8'h91;
  logic [7:0] tempHi = 8'h01;
  logic [CW-1:0] convCycles;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0] eTh, eTl;
  logic [1:0] eRes;

  always #4 clk = ~clk;

  scratch_cmd_engine #(
    .NV_CYCLES(NV), .CONV_W(CW), .CONV_FULL(CF),
    .NV_TH_INIT(TH0), .NV_TL_INIT(TL0), .NV_RES_INIT(2'b11)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .cmdValid(cmdValid),
    .cmdByte(cmdByte), .wrBitValid(wrBitValid), .wrBit(wrBit),
    .rdSlotReq(rdSlotReq), .rdBit(rdBit), .tempLo(tempLo), .tempHi(tempHi),
    .convCycles(convCycles)
  );

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] c);
    @(negedge clk); cmdValid = 1'b1; cmdByte = c;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic writeBits(input logic [23:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wrBitValid = 1'b1; wrBit = v[i];
      @(negedge clk); wrBitValid = 1'b0;
    end
  endtask

  task automatic readBits(output logic [71:0] v, input int n);
    v = '1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); v[i] = rdBit; rdSlotReq = 1'b1;
      @(negedge clk); rdSlotReq = 1'b0;
    end
  endtask

  task automatic pulseBusReset();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  function automatic logic [71:0] expFrame();
    logic [7:0] b [9];
    logic [7:0] c;
    b[0] = tempLo; b[1] = tempHi; b[2] = eTh; b[3] = eTl;
    b[4] = {1'b0, eRes, 5'h1F}; b[5] = 8'hFF; b[6] = 8'h0C; b[7] = 8'h10;
    c = 8'h00;
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 8; j++)
        c = (c[0] ^ b[k][j]) ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    b[8] = c;
    return {b[8], b[7], b[6], b[5], b[4], b[3], b[2], b[1], b[0]};
  endfunction

  task automatic readAll(input string tag);
    logic [71:0] got;
    sendCmd(8'hBE);
    readBits(got, 72);
    chk(tag, got, expFrame());
  endtask

  task automatic countLow(input string tag);
    int lows = 0;
    for (int i = 0; i < NV + 5; i++) begin
      if (!rdBit) lows++;
      @(negedge clk);
    end
    chk(tag, 72'(lows), 72'(NV));
  endtask

  initial begin
    logic [71:0] got;
    logic [7:0] cfgW;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    eTh = TH0; eTl = TL0; eRes = 2'b11;
    @(negedge clk);
    chk("R12 idle line high after reset", 72'(rdBit), 72'd1);
    chk("R8 reset conv full", 72'(convCycles), 72'(CF));
    readAll("R7 R2 R3 power-up frame");

    // R1 R4 R8 R2 R3: sweep resolution and alarm patterns
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 3; k++) begin
        eTh = 8'(k * 8'h37 + r * 8'h11 + 5);
        eTl = ~eTh ^ 8'(r);
        cfgW = {1'(k), 2'(r), 5'(k * 7 + 2)};
        eRes = 2'(r);
        tempLo = 8'(r * 8'h29 + k);
        tempHi = 8'(k * 8'h13 ^ r);
        sendCmd(8'h4E);
        writeBits({cfgW, eTl, eTh}, 24);
        readAll("R1 R4 R2 R3 write-read sweep");
      end
      chk("R8 conv scaled", 72'(convCycles), 72'(CF >> (3 - r)));
    end
    writeBits(24'hFFFFFF, 8);
    readAll("R1 bits after 24th ignored");

    // R5 R6: copy, overwrite, recall
    eTh = 8'hA5; eTl = 8'h3C; eRes = 2'b01;
    sendCmd(8'h4E); writeBits({8'h20, eTl, eTh}, 24);
    sendCmd(8'h48);
    countLow("R5 copy busy window");
    readAll("R5 copy leaves scratchpad");
    sendCmd(8'h4E); writeBits({8'hC0, 8'h77, 8'h66}, 24);
    eTh = 8'h66; eTl = 8'h77; eRes = 2'b10;
    readAll("R1 overwrite before recall");
    sendCmd(8'hB8);
    countLow("R6 recall busy window");
    eTh = 8'hA5; eTl = 8'h3C; eRes = 2'b01;
    chk("R6 line high after recall", 72'(rdBit), 72'd1);
    readAll("R6 recall restores");

    // R9: abort mid-write
    sendCmd(8'h4E);
    writeBits(24'h000511, 11);
    pulseBusReset();
    writeBits(24'h00001F, 5);
    eTh = 8'h11;
    readAll("R9 abort keeps full byte only");

    // R10: abort mid-read
    sendCmd(8'hBE);
    readBits(got, 12);
    chk("R10 partial read bits", got[11:0], expFrame() & 72'hFFF);
    pulseBusReset();
    @(negedge clk);
    chk("R10 line high after abort", 72'(rdBit), 72'd1);
    readAll("R10 read restarts at byte 0");

    // R11: unknown command
    sendCmd(8'h55);
    @(negedge clk);
    chk("R11 unknown code line high", 72'(rdBit), 72'd1);
    writeBits(24'h0000AA, 8);
    readAll("R11 unknown code no effect");

    // R12: command during shadow access ignored
    sendCmd(8'h48);
    sendCmd(8'h4E);
    writeBits(24'hFFFFFF, 24);
    repeat (NV + 2) @(negedge clk);
    readAll("R12 command during busy ignored");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R12 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule